// File: doc/BRIEF.md
# Histogram-Voting Illumination Controller

This block takes a depth camera's pixel stream and decides once per frame whether the active illumination should step up, step down or stay where it is. Each incoming pixel carries a phase value, which stands for distance, and a confidence value. The phase is mapped onto one of 30 distance bins. The block counts how many pixels land in each bin. It also counts how many of those pixels reach a confidence threshold that can be set separately for every bin.

When the last pixel of a frame has been taken, a greedy search starts. In each step it picks the most populated bin that has not yet been picked. That bin votes according to the share of its pixels that passed the confidence test. The search stops as soon as the picked bins together hold a programmable percentage of the frame. The two vote totals are weighted and summed, and the sign of the sum is the step. After the step has been emitted, all counts are cleared and the next frame begins.

Pixels arrive through a valid/ready port backed by a small FIFO. Steps leave through a valid/ready port backed by a second FIFO. The thresholds, the coverage percentage and the two weights are held on configuration inputs, which stay constant while a frame is in flight.

Top module: `illum_vote_ctrl`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: A pixel's bin is (phase * 3) >> 8. Any result above 29 is forced to bin 29, so phase 85 falls in bin 0, phase 86 in bin 1 and phase 4095 in bin 29.
- R3: A pixel passes when its confidence is greater than or equal to the threshold of its bin. The threshold for bin b sits in cfg_conf_thresh bits [b*12 +: 12].
- R4: After a frame, bins are picked largest first, and equal counts go to the lower bin index. Picking goes on while covered*100 < cfg_cover_pct*4800, where covered is the sum of the picked bins' counts, so a percentage of 0 picks nothing. The search never makes more than 30 picks.
- R5: A picked bin with total count t > 0 and passing count p casts a "down" vote when 4p <= t and an "up" vote when 4p >= 3t. Otherwise it casts no vote.
- R6: The score is w_up*ups - w_down*downs, with both weights signed 8-bit. out_step is 2'b01 for a positive score, 2'b11 for a negative score and 2'b00 for zero. The code 2'b10 never appears.
- R7: Exactly one step is produced for every 4800 accepted pixels, and steps come out in frame order. No count carries over into the next frame.
- R8: While out_valid is high and out_ready is low, out_valid and out_step hold steady. Pixels offered while in_ready is low are not taken, and no accepted pixel is lost.
- R9: With out_ready held high, the step is visible on out_valid within 64 cycles after the frame's last pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Input FIFO can take a pixel |
| in_phase | input | 12 | Pixel phase (distance) |
| in_conf | input | 12 | Pixel confidence |
| cfg_conf_thresh | input | 360 | Per-bin confidence thresholds, 12 bits each |
| cfg_cover_pct | input | 7 | Coverage percentage that ends the search |
| cfg_weight_up | input | 8 | Signed weight of up votes |
| cfg_weight_down | input | 8 | Signed weight of down votes |
| out_valid | output | 1 | Step available |
| out_ready | input | 1 | Consumer takes the step |
| out_step | output | 2 | Illumination step: 01 up, 11 down, 00 hold |

## Verification
A frame's step is due within 64 cycles of the handshake on its last pixel: a few cycles to drain the input FIFO, at most 31 search cycles, one cycle to emit, and one cycle in the output FIFO. The directed frames wait for it inside exactly that window. On every clock where out_valid is high, the bench compares out_step against the head of a queue of expected steps. Because this comparison repeats while the output is stalled, a step that changes during backpressure is caught. The expected steps are either worked out by hand for the directed frames or computed by a behavioural histogram-and-vote model for random frames, which are streamed back to back with gaps on the input and a stalling consumer.

// File: rtl/illum_vote_pkg.sv
`timescale 1ns/1ps
package illum_vote_pkg;
  // Strobes from the sequencer to the counting and voting datapath
  typedef struct packed {
    logic acceptPix;  // take the FIFO head pixel into the histogram
    logic pickBin;    // pick the largest unpicked bin and let it vote
    logic clearAll;   // wipe all per-frame state
  } vote_strobe_t;

  localparam logic [1:0] STEP_HOLD = 2'b00;
  localparam logic [1:0] STEP_UP   = 2'b01;
  localparam logic [1:0] STEP_DOWN = 2'b11;
endpackage

// File: rtl/ivc_fifo.sv
`timescale 1ns/1ps
module ivc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ivc_datapath.sv
`timescale 1ns/1ps
module ivc_datapath
  import illum_vote_pkg::*;
#(
  parameter int NUM_BINS  = 30,
  parameter int PIXELS    = 4800,
  parameter int PHASE_W   = 12,
  parameter int CONF_W    = 12,
  parameter int BIN_MUL   = 3,
  parameter int BIN_SHIFT = 8,
  parameter int PCT_W     = 7,
  parameter int WT_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  vote_strobe_t               stb,
  input  logic [PHASE_W-1:0]         phase,
  input  logic [CONF_W-1:0]          conf,
  input  logic [NUM_BINS*CONF_W-1:0] confThresh,
  input  logic [PCT_W-1:0]           coverPct,
  input  logic signed [WT_W-1:0]     weightUp,
  input  logic signed [WT_W-1:0]     weightDown,
  output logic                       coverDone,
  output logic [1:0]                 stepCode
);
  localparam int CNT_W  = $clog2(PIXELS + 1);
  localparam int IDX_W  = $clog2(NUM_BINS);
  localparam int VOTE_W = $clog2(NUM_BINS + 1);
  localparam int PROD_W = PHASE_W + $clog2(BIN_MUL + 1);
  localparam int CMP_W  = CNT_W + PCT_W + 1;
  localparam int RAT_W  = CNT_W + 2;
  localparam int SC_W   = WT_W + VOTE_W + 2;

  logic [CNT_W-1:0]  histCnt [NUM_BINS];
  logic [CNT_W-1:0]  passCnt [NUM_BINS];
  logic [NUM_BINS-1:0] chosen;
  logic [CNT_W-1:0]  covered;
  logic [VOTE_W-1:0] nUp, nDown;

  // Per-bin thresholds unpacked from the flat configuration word
  logic [CONF_W-1:0] thrArr [NUM_BINS];
  for (genvar g = 0; g < NUM_BINS; g++) begin : g_thr
    assign thrArr[g] = confThresh[g*CONF_W +: CONF_W];
  end

  // Phase to bin: scale by a fixed reciprocal, then clamp to the last bin
  logic [PROD_W-1:0] binProd, binRaw;
  logic [IDX_W-1:0]  binIdx;
  logic              passNow;
  assign binProd = PROD_W'(phase) * PROD_W'(BIN_MUL);
  assign binRaw  = binProd >> BIN_SHIFT;
  assign binIdx  = (binRaw > PROD_W'(NUM_BINS - 1)) ? IDX_W'(NUM_BINS - 1) : binRaw[IDX_W-1:0];
  assign passNow = (conf >= thrArr[binIdx]);

  // Largest unpicked bin; strict compare keeps the lower index on ties
  logic [IDX_W-1:0] bestIdx;
  logic [CNT_W-1:0] bestVal;
  logic             bestFound;
  always_comb begin
    bestIdx   = '0;
    bestVal   = '0;
    bestFound = 1'b0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (!chosen[b] && (!bestFound || histCnt[b] > bestVal)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(b);
        bestVal   = histCnt[b];
      end
    end
  end

  // Ratio votes by cross-multiplication, no divider
  logic [RAT_W-1:0] pass4, total1, total3;
  logic             voteDown, voteUp;
  assign pass4    = RAT_W'(passCnt[bestIdx]) << 2;
  assign total1   = RAT_W'(bestVal);
  assign total3   = RAT_W'(bestVal) * RAT_W'(3);
  assign voteDown = (bestVal != '0) && (pass4 <= total1);
  assign voteUp   = (bestVal != '0) && (pass4 >= total3);

  // Coverage test against the programmed fraction of the frame
  logic [CMP_W-1:0] coverLhs, coverRhs;
  assign coverLhs  = CMP_W'(covered) * CMP_W'(100);
  assign coverRhs  = CMP_W'(coverPct) * CMP_W'(PIXELS);
  assign coverDone = (coverLhs >= coverRhs) || (&chosen);

  always_ff @(posedge clk) begin
    if (rst || stb.clearAll) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        histCnt[b] <= '0;
        passCnt[b] <= '0;
      end
      chosen  <= '0;
      covered <= '0;
      nUp     <= '0;
      nDown   <= '0;
    end else begin
      if (stb.acceptPix) begin
        histCnt[binIdx] <= histCnt[binIdx] + CNT_W'(1);
        if (passNow) passCnt[binIdx] <= passCnt[binIdx] + CNT_W'(1);
      end
      if (stb.pickBin) begin
        chosen[bestIdx] <= 1'b1;
        covered         <= covered + bestVal;
        if (voteDown) nDown <= nDown + VOTE_W'(1);
        if (voteUp)   nUp   <= nUp + VOTE_W'(1);
      end
    end
  end

  // Weighted score and its sign
  logic signed [SC_W-1:0] score;
  assign score = SC_W'(weightUp) * SC_W'($signed({1'b0, nUp}))
               - SC_W'(weightDown) * SC_W'($signed({1'b0, nDown}));
  assign stepCode = (score == '0) ? STEP_HOLD : ((score < 0) ? STEP_DOWN : STEP_UP);
endmodule

// File: rtl/ivc_control.sv
`timescale 1ns/1ps
module ivc_control
  import illum_vote_pkg::*;
#(
  parameter int PIXELS = 4800
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inEmpty,
  input  logic         outFull,
  input  logic         coverDone,
  output vote_strobe_t stb,
  output logic         outPush
);
  localparam int PIX_W = $clog2(PIXELS);

  typedef enum logic [1:0] {ST_FILL, ST_SEARCH, ST_EMIT} ctl_state_e;
  ctl_state_e       state;
  logic [PIX_W-1:0] pixCnt;

  always_comb begin
    stb     = '0;
    outPush = 1'b0;
    case (state)
      ST_FILL:   stb.acceptPix = !inEmpty;
      ST_SEARCH: stb.pickBin   = !coverDone;
      ST_EMIT: begin
        outPush      = !outFull;
        stb.clearAll = !outFull;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FILL;
      pixCnt <= '0;
    end else begin
      case (state)
        ST_FILL: if (stb.acceptPix) begin
          if (pixCnt == PIX_W'(PIXELS - 1)) begin
            pixCnt <= '0;
            state  <= ST_SEARCH;
          end else begin
            pixCnt <= pixCnt + PIX_W'(1);
          end
        end
        ST_SEARCH: if (coverDone) state <= ST_EMIT;
        ST_EMIT:   if (outPush) state <= ST_FILL;
        default:   state <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/illum_vote_ctrl.sv
`timescale 1ns/1ps
module illum_vote_ctrl
  import illum_vote_pkg::*;
#(
  parameter int NUM_BINS  = 30,
  parameter int PIXELS    = 4800,
  parameter int PHASE_W   = 12,
  parameter int CONF_W    = 12,
  parameter int BIN_MUL   = 3,
  parameter int BIN_SHIFT = 8,
  parameter int PCT_W     = 7,
  parameter int WT_W      = 8,
  parameter int IN_DEPTH  = 4,
  parameter int OUT_DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PHASE_W-1:0]         in_phase,
  input  logic [CONF_W-1:0]          in_conf,
  input  logic [NUM_BINS*CONF_W-1:0] cfg_conf_thresh,
  input  logic [PCT_W-1:0]           cfg_cover_pct,
  input  logic signed [WT_W-1:0]     cfg_weight_up,
  input  logic signed [WT_W-1:0]     cfg_weight_down,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [1:0]                 out_step
);
  localparam int PIX_BITS = PHASE_W + CONF_W;

  vote_strobe_t        stb;
  logic                inFull, inEmpty, outFull, outEmpty, outPush, coverDone;
  logic [PIX_BITS-1:0] headPix;
  logic [1:0]          stepCode;

  assign in_ready  = !inFull;
  assign out_valid = !outEmpty;

  ivc_fifo #(.W(PIX_BITS), .DEPTH(IN_DEPTH)) u_inFifo (
    .clk(clk), .rst(rst),
    .push(in_valid), .pushData({in_phase, in_conf}),
    .pop(stb.acceptPix), .popData(headPix),
    .full(inFull), .empty(inEmpty)
  );

  ivc_control #(.PIXELS(PIXELS)) u_ctrl (
    .clk(clk), .rst(rst),
    .inEmpty(inEmpty), .outFull(outFull), .coverDone(coverDone),
    .stb(stb), .outPush(outPush)
  );

  ivc_datapath #(
    .NUM_BINS(NUM_BINS), .PIXELS(PIXELS), .PHASE_W(PHASE_W), .CONF_W(CONF_W),
    .BIN_MUL(BIN_MUL), .BIN_SHIFT(BIN_SHIFT), .PCT_W(PCT_W), .WT_W(WT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .phase(headPix[PIX_BITS-1:CONF_W]), .conf(headPix[CONF_W-1:0]),
    .confThresh(cfg_conf_thresh), .coverPct(cfg_cover_pct),
    .weightUp(cfg_weight_up), .weightDown(cfg_weight_down),
    .coverDone(coverDone), .stepCode(stepCode)
  );

  ivc_fifo #(.W(2), .DEPTH(OUT_DEPTH)) u_outFifo (
    .clk(clk), .rst(rst),
    .push(outPush), .pushData(stepCode),
    .pop(out_ready), .popData(out_step),
    .full(outFull), .empty(outEmpty)
  );
endmodule

// File: rtl/illum_vote_ctrl_chk.sv
`timescale 1ns/1ps
module illum_vote_ctrl_chk #(
  parameter int NUM_BINS = 30
) (
  input logic       clk,
  input logic       rst,
  input logic       outValid,
  input logic       outReady,
  input logic [1:0] outStep,
  input logic       pickBin,
  input logic       coverDone
);
  localparam int RUN_W = $clog2(NUM_BINS + 2);
  logic [RUN_W-1:0] pickRun;

  always_ff @(posedge clk) begin
    if (rst)          pickRun <= '0;
    else if (pickBin) pickRun <= pickRun + RUN_W'(1);
    else              pickRun <= '0;
  end

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outStep != 2'b10)); // R6

  AST_OUT_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outStep))); // R8

  AST_NO_PICK_AFTER_COVER: assert property (@(posedge clk) disable iff (rst)
    coverDone |-> !pickBin); // R4

  AST_PICK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pickBin |-> (pickRun < RUN_W'(NUM_BINS))); // R4
endmodule

bind illum_vote_ctrl illum_vote_ctrl_chk #(.NUM_BINS(NUM_BINS)) u_chk (
  .clk(clk), .rst(rst), .outValid(out_valid), .outReady(out_ready),
  .outStep(out_step), .pickBin(stb.pickBin), .coverDone(coverDone)
);

// File: tb/illum_vote_ctrl_bench.sv
`timescale 1ns/1ps
module illum_vote_ctrl_bench;
  localparam int NB  = 30;
  localparam int PIX = 4800;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [11:0]     in_phase = '0;
  logic [11:0]     in_conf = '0;
  logic [NB*12-1:0] cfg_conf_thresh = '0;
  logic [6:0]      cfg_cover_pct = '0;
  logic [7:0]      cfg_weight_up = '0;
  logic [7:0]      cfg_weight_down = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [1:0]      out_step;

  always #10 clk = ~clk;

  illum_vote_ctrl u_illum_vote_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .in_conf(in_conf), .cfg_conf_thresh(cfg_conf_thresh),
    .cfg_cover_pct(cfg_cover_pct), .cfg_weight_up(cfg_weight_up),
    .cfg_weight_down(cfg_weight_down), .out_valid(out_valid),
    .out_ready(out_ready), .out_step(out_step)
  );

  int    checks = 0, failures = 0;
  int    cyc = 0;
  int    phArr [PIX];
  int    cfArr [PIX];
  int    thr [NB];
  int    covPct, wUp, wDown;
  int    expQ[$];
  string tagQ[$];
  bit    readyRandom = 0;

  function automatic void check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endfunction

  function automatic int decodeStep(logic [1:0] s);
    case (s)
      2'b01:   return 1;
      2'b11:   return -1;
      2'b00:   return 0;
      default: return 99;
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Output monitor: drives out_ready and compares on every clock
  always @(negedge clk) begin
    if (!rst) begin
      bit nr;
      cyc++;
      if (cyc > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        summary();
      end
      nr = readyRandom ? ($urandom_range(0, 2) != 0) : 1'b1;
      out_ready = nr;
      if (out_valid) begin
        if (expQ.size() == 0) begin
          check(0, "R7 step with no frame pending", decodeStep(out_step), 0);
        end else begin
          check(decodeStep(out_step) == expQ[0], tagQ[0], decodeStep(out_step), expQ[0]);
          if (nr) begin
            void'(expQ.pop_front());
            void'(tagQ.pop_front());
          end
        end
      end
    end
  end

  task automatic applyCfg();
    for (int b = 0; b < NB; b++) cfg_conf_thresh[b*12 +: 12] = 12'(thr[b]);
    cfg_cover_pct   = 7'(covPct);
    cfg_weight_up   = 8'(wUp);
    cfg_weight_down = 8'(wDown);
  endtask

  task automatic setCfg(int t, int cp, int wu, int wd);
    for (int b = 0; b < NB; b++) thr[b] = t;
    covPct = cp; wUp = wu; wDown = wd;
    applyCfg();
  endtask

  task automatic fillSeg(int start, int count, int ph, int cf);
    for (int i = start; i < start + count; i++) begin
      phArr[i] = ph;
      cfArr[i] = cf;
    end
  endtask

  task automatic sendFrame(bit gaps);
    for (int i = 0; i < PIX; i++) begin
      if (gaps && $urandom_range(0, 7) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_phase = 12'(phArr[i]);
      in_conf  = 12'(cfArr[i]);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Behavioural model for random frames
  function automatic int modelStep();
    int  hist [NB];
    int  pass [NB];
    bit  used [NB];
    int  covered = 0, ups = 0, downs = 0, s;
    for (int b = 0; b < NB; b++) begin hist[b] = 0; pass[b] = 0; used[b] = 0; end
    for (int i = 0; i < PIX; i++) begin
      int b = (phArr[i] * 3) / 256;
      if (b > NB - 1) b = NB - 1;
      hist[b]++;
      if (cfArr[i] >= thr[b]) pass[b]++;
    end
    for (int k = 0; k < NB; k++) begin
      int best = -1;
      if (covered * 100 >= covPct * PIX) break;
      for (int b = 0; b < NB; b++)
        if (!used[b] && (best < 0 || hist[b] > hist[best])) best = b;
      used[best] = 1;
      covered += hist[best];
      if (hist[best] > 0) begin
        if (4 * pass[best] <= hist[best]) downs++;
        if (4 * pass[best] >= 3 * hist[best]) ups++;
      end
    end
    s = wUp * ups - wDown * downs;
    return (s > 0) ? 1 : ((s < 0) ? -1 : 0);
  endfunction

  // One frame with a hand-derived expected step; waits for the step (R9)
  task automatic runSeq(int exp, string tag);
    bit seen = 0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    sendFrame(0);
    for (int i = 0; i < 64; i++) begin
      if (out_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, {"R9 latency ", tag}, seen, 1);
    @(negedge clk);
  endtask

  initial begin
    covPct = 0; wUp = 0; wDown = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R5 all pass / all fail in a single bin
    setCfg(2048, 50, 1, 1);
    fillSeg(0, PIX, 0, 4000);
    runSeq(1, "R5 all confident -> up");
    fillSeg(0, PIX, 0, 100);
    runSeq(-1, "R5 none confident -> down");
    fillSeg(0, 2400, 0, 4000); fillSeg(2400, 2400, 0, 100);
    runSeq(0, "R5 ratio one half -> hold");
    fillSeg(0, 1200, 0, 4000); fillSeg(1200, 3600, 0, 100);
    runSeq(-1, "R5 ratio exactly quarter -> down");
    fillSeg(0, 3600, 0, 4000); fillSeg(3600, 1200, 0, 100);
    runSeq(1, "R5 ratio exactly three quarters -> up");

    // R4 tie goes to lower bin (bin 5 confident, bin 10 not)
    fillSeg(0, 2400, 900, 100); fillSeg(2400, 2400, 430, 4000);
    runSeq(1, "R4 tie picks lower bin");
    setCfg(2048, 51, 1, 1);
    runSeq(0, "R6 zero score -> hold");
    setCfg(2048, 51, -3, 1);
    runSeq(-1, "R6 negative up weight");
    setCfg(2048, 51, 2, -5);
    runSeq(1, "R6 negative down weight");

    // R4 greedy stop: bin9 3000 low, bin21 1000 high, bin29 800 high
    setCfg(2048, 70, 1, 2);
    fillSeg(0, 3000, 800, 100); fillSeg(3000, 1000, 1800, 4000); fillSeg(4000, 800, 2500, 4000);
    runSeq(-1, "R4 search stops at coverage");
    setCfg(2048, 0, 1, 1);
    fillSeg(0, PIX, 0, 4000);
    runSeq(0, "R4 zero coverage -> hold");

    // R2 clamp to bin 29 and bin edge 85/86
    setCfg(4095, 50, 1, 1); thr[29] = 900; applyCfg();
    fillSeg(0, PIX, 4095, 1000);
    runSeq(1, "R2 clamp uses bin 29 threshold (pass)");
    thr[29] = 1100; applyCfg();
    runSeq(-1, "R2 clamp uses bin 29 threshold (fail)");
    setCfg(4095, 50, 1, 1); thr[1] = 900; applyCfg();
    fillSeg(0, PIX, 86, 1000);
    runSeq(1, "R2 phase 86 in bin 1");
    fillSeg(0, PIX, 85, 1000);
    runSeq(-1, "R2 phase 85 in bin 0");

    // R3 confidence equal to threshold passes
    setCfg(2048, 50, 1, 1);
    fillSeg(0, PIX, 300, 2048);
    runSeq(1, "R3 confidence equal to threshold");

    // R7 R8 random frames back to back with gaps and a stalling consumer
    setCfg(0, 60, 2, 1);
    for (int b = 0; b < NB; b++) thr[b] = 1000 + 97 * b;
    applyCfg();
    readyRandom = 1;
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < PIX; i++) begin
        phArr[i] = (f == 1) ? $urandom_range(0, 1200) : $urandom_range(0, 4095);
        cfArr[i] = $urandom_range(0, 4095);
      end
      expQ.push_back(modelStep());
      tagQ.push_back("R7 R8 random frame");
      sendFrame(1);
    end
    for (int i = 0; i < 3000 && expQ.size() > 0; i++) @(negedge clk);
    check(expQ.size() == 0, "R7 all frames produced a step", expQ.size(), 0);
    readyRandom = 0;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R7 no extra step", out_valid, 0);
    summary();
  end
endmodule